// File: doc/BRIEF.md
# Flash Command Sequence Executor

This block runs a short, programmed list of instruction words and turns each one into a phase on a quad serial flash interface. Software fills a small list of 16-bit words through a write port. A start strobe then makes the block walk the list from entry 0. Each word can send a command byte, a column address, or a group of mode bits, in single or double data rate, on one, two or four data lines. A STOP word ends the list early.

The block drives chip select, a serial clock enable and a serial clock at half the core clock rate, four data outputs and their per-pad enables. A one-cycle done pulse marks the end of every sequence. The column address comes either from a bus-side transfer address or from a programmed address register, selected by an input. An address narrower than the pad group is filled with zero bits to complete the last group.

Top module: `flash_seq_exec`

## Requirements
- R1: After reset, cs_n is 1, and sck_en, sck, io_oe, io_out and done are all 0.
- R2: A start pulse while idle makes cs_n go to 0 in the next cycle. Entries then execute in order from index 0. Word layout: opcode in bits [15:10], pad code in [9:8] (0 = one pad, 1 = two pads, 2 or 3 = four pads), operand in [7:0]. Opcodes: 0 STOP, 1 command byte, 2 column address, 3 two mode bits, 4 four mode bits, 5 two mode bits DDR, 6 four mode bits DDR. Any other opcode is a no-op.
- R3: Each entry begins with one fetch cycle, in which cs_n is 0 and sck_en is 0. A no-op entry takes only that cycle. A transferring entry then takes its shift cycles, during which sck_en is 1.
- R4: Data is sent MSB first. With one pad, the bit is on io_out[0] and io_oe is 0001. With two pads, the earlier bit is on io_out[1] and io_oe is 0011. With four pads, the earliest bit is on io_out[3] and io_oe is 1111. Outside shift cycles, io_oe and io_out are 0.
- R5: In single data rate, each pad group is held for one serial cycle of two core cycles, with sck 0 and then 1. sck is 0 whenever sck_en is 0.
- R6: A command-byte entry sends operand[7:0] in 8/pads serial cycles.
- R7: The two-bit mode entry sends operand[1:0] and the four-bit mode entry sends operand[3:0]. Each lasts ceil(bits/pads) serial cycles, so two bits on one pad take 2 cycles and four bits on four pads take 1. Pads left unused in a group carry 0.
- R8: The DDR mode entries change the pad group on every core cycle, that is, on every serial clock edge, with sck alternating from 0. Two bits on one pad take one serial cycle. Four bits on one pad take two. Four bits on four pads take a single edge.
- R9: A column-address entry takes its width w from operand[5:0], limited to ADDR_W. It sends the low w address bits MSB first in ceil(w/pads) serial cycles and appends zero bits to fill the last group. w = 0 behaves as a no-op.
- R10: addr_from_bus = 1 selects bus_addr as the address source, and 0 selects reg_addr. The source is sampled at the fetch of the address entry.
- R11: A STOP entry ends the sequence. In the next cycle cs_n is 1 and done is 1 for exactly one cycle, and no later entry executes.
- R12: When the last list entry finishes its final shift cycle, the next cycle has cs_n at 1 and a one-cycle done pulse.
- R13: A start pulse is ignored while cs_n is 0 and during the done cycle. No extra sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write strobe for the instruction list |
| prog_idx | input | $clog2(DEPTH) | List entry to write |
| prog_word | input | 16 | Instruction word to store |
| start | input | 1 | Start strobe for a sequence |
| addr_from_bus | input | 1 | 1 selects bus_addr, 0 selects reg_addr |
| bus_addr | input | ADDR_W | Address of the incoming bus transfer |
| reg_addr | input | ADDR_W | Programmed address register value |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock (core clock divided by two) |
| sck_en | output | 1 | High in every cycle that carries a serial edge |
| io_out | output | 4 | Data outputs to the flash pads |
| io_oe | output | 4 | Per-pad output enables |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The bound checker checks the framing rules on every cycle:
- clock activity only inside an asserted chip select;
- sck silent and pads released outside shift cycles;
- a legal pad-enable pattern whenever data moves;
- chip select falling only after a start;
- chip select rising only together with a single-cycle done.

Only the bench's scenarios can show the rest:
- the actual bit order and zero padding on the pads;
- the per-phase cycle counts for each pad width and data rate;
- address clamping and the choice of address source;
- early termination by STOP;
- that a start arriving mid-sequence or during done leaves no trace.

// File: rtl/flseq_pkg.sv
// Shared opcode values and state type for the flash sequence executor.
// Assumes: opcodes sit in bits [15:10] of a 16-bit instruction word.
package flseq_pkg;

    localparam int WORD_W = 16;

    localparam logic [5:0] OP_STOP      = 6'd0;
    localparam logic [5:0] OP_CMD       = 6'd1;
    localparam logic [5:0] OP_ADDR      = 6'd2;
    localparam logic [5:0] OP_MODE2     = 6'd3;
    localparam logic [5:0] OP_MODE4     = 6'd4;
    localparam logic [5:0] OP_MODE2_DDR = 6'd5;
    localparam logic [5:0] OP_MODE4_DDR = 6'd6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/flseq_regfile.sv
// Instruction list storage: one write port, one asynchronous read port.
// Assumes: DEPTH entries, cleared to zero (STOP) by reset.
module flseq_regfile #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Store a word on write; clear the whole list on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/flseq_decode.sv
// Combinational decode of one instruction word.
// Produces the pad width (log2), data-rate flag, number of pad groups to send,
// and an MSB-aligned load value whose low bits are zero (the zero fill).
// Assumes: SR_W >= max(ADDR_W, 8); CNT_W can hold SR_W + 3.
module flseq_decode
    import flseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SR_W   = 24,
    parameter int CNT_W  = 5
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_stop,
    output logic              ddr,
    output logic [1:0]        plog,
    output logic [CNT_W-1:0]  units,
    output logic [SR_W-1:0]   load_val
);

    logic [5:0]       opc;
    logic [7:0]       operand;
    logic [CNT_W-1:0] bits;
    logic [CNT_W-1:0] pmask;
    logic [CNT_W-1:0] shamt;
    logic [SR_W-1:0]  raw;

    // Split the word, pick bit count and raw payload per opcode.
    always_comb begin
        opc     = word[15:10];
        operand = word[7:0];
        is_stop = (opc == OP_STOP);
        ddr     = 1'b0;
        bits    = '0;
        raw     = '0;
        case (word[9:8])
            2'd0:    plog = 2'd0;
            2'd1:    plog = 2'd1;
            default: plog = 2'd2;
        endcase
        case (opc)
            OP_CMD: begin
                bits = CNT_W'(8);
                raw  = SR_W'(operand);
            end
            OP_ADDR: begin
                if ({2'b00, operand[5:0]} > 8'(ADDR_W)) begin
                    bits = CNT_W'(ADDR_W);
                end else begin
                    bits = CNT_W'(operand[5:0]);
                end
                raw = SR_W'(addr);
            end
            OP_MODE2: begin
                bits = CNT_W'(2);
                raw  = SR_W'(operand[1:0]);
            end
            OP_MODE4: begin
                bits = CNT_W'(4);
                raw  = SR_W'(operand[3:0]);
            end
            OP_MODE2_DDR: begin
                bits = CNT_W'(2);
                raw  = SR_W'(operand[1:0]);
                ddr  = 1'b1;
            end
            OP_MODE4_DDR: begin
                bits = CNT_W'(4);
                raw  = SR_W'(operand[3:0]);
                ddr  = 1'b1;
            end
            default: begin
                bits = '0;
            end
        endcase
    end

    // Round the bit count up to whole pad groups and MSB-align the payload.
    always_comb begin
        case (plog)
            2'd0:    pmask = CNT_W'(0);
            2'd1:    pmask = CNT_W'(1);
            default: pmask = CNT_W'(3);
        endcase
        units    = (bits + pmask) >> plog;
        shamt    = CNT_W'(SR_W) - bits;
        load_val = raw << shamt;
    end

endmodule

// File: rtl/flseq_shifter.sv
// MSB-first output shift register with pad mapping.
// The earliest bit of each group goes to the highest used pad.
// Assumes: plog is held stable while shifting (0 = 1 pad, 1 = 2, 2 = 4).
module flseq_shifter #(
    parameter int SR_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift_en,
    input  logic [1:0]      plog,
    input  logic            drive,
    output logic [3:0]      io_out,
    output logic [3:0]      io_oe
);

    logic [SR_W-1:0] sr;

    // Load a new payload, or advance by one pad group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load_en) begin
            sr <= load_val;
        end else if (shift_en) begin
            case (plog)
                2'd0:    sr <= sr << 1;
                2'd1:    sr <= sr << 2;
                default: sr <= sr << 4;
            endcase
        end
    end

    // Present the top group on the pads while driving.
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (drive) begin
            case (plog)
                2'd0: begin
                    io_out = {3'b000, sr[SR_W-1]};
                    io_oe  = 4'b0001;
                end
                2'd1: begin
                    io_out = {2'b00, sr[SR_W-1 -: 2]};
                    io_oe  = 4'b0011;
                end
                default: begin
                    io_out = sr[SR_W-1 -: 4];
                    io_oe  = 4'b1111;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_seq_exec.sv
// Flash command sequence executor, top level.
// Walks the instruction list from entry 0 and runs one fetch cycle per entry,
// then the entry's shift cycles. Ends on STOP or after the last entry, then
// pulses done with chip select released.
// Assumes: the serial clock is the core clock divided by two; an SDR group
// lasts two core cycles and a DDR group one core cycle (one serial edge).
module flash_seq_exec
    import flseq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 24,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SR_W  = (ADDR_W > 8) ? ADDR_W : 8,
    localparam int CNT_W = $clog2(SR_W + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [15:0]       prog_word,
    input  logic              start,
    input  logic              addr_from_bus,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              cs_n,
    output logic              sck,
    output logic              sck_en,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] pc;
    logic [CNT_W-1:0] units_left;
    logic             half;
    logic             ddr_q;
    logic [1:0]       plog_q;

    logic [WORD_W-1:0] cur_word;
    logic [ADDR_W-1:0] addr_sel;
    logic              dec_stop;
    logic              dec_ddr;
    logic [1:0]        dec_plog;
    logic [CNT_W-1:0]  dec_units;
    logic [SR_W-1:0]   dec_load;
    logic              step;

    flseq_regfile #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_list (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .widx  (prog_idx),
        .wdata (prog_word),
        .ridx  (pc),
        .rdata (cur_word)
    );

    // Choose the column address source.
    always_comb begin
        addr_sel = addr_from_bus ? bus_addr : reg_addr;
    end

    flseq_decode #(
        .ADDR_W (ADDR_W),
        .SR_W   (SR_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .word     (cur_word),
        .addr     (addr_sel),
        .is_stop  (dec_stop),
        .ddr      (dec_ddr),
        .plog     (dec_plog),
        .units    (dec_units),
        .load_val (dec_load)
    );

    // A group completes every edge in DDR, every second edge in SDR.
    always_comb begin
        step = (state == ST_SHIFT) && (ddr_q || half);
    end

    // Sequence control: fetch, shift, advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pc         <= '0;
            units_left <= '0;
            half       <= 1'b0;
            ddr_q      <= 1'b0;
            plog_q     <= 2'd0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_FETCH;
                        pc    <= '0;
                    end
                end
                ST_FETCH: begin
                    if (dec_stop) begin
                        state <= ST_DONE;
                    end else if (dec_units == '0) begin
                        if (pc == LAST_IDX) begin
                            state <= ST_DONE;
                        end else begin
                            pc <= pc + 1'b1;
                        end
                    end else begin
                        state      <= ST_SHIFT;
                        units_left <= dec_units;
                        half       <= 1'b0;
                        ddr_q      <= dec_ddr;
                        plog_q     <= dec_plog;
                    end
                end
                ST_SHIFT: begin
                    half <= ~half;
                    if (step) begin
                        units_left <= units_left - 1'b1;
                        if (units_left == CNT_W'(1)) begin
                            if (pc == LAST_IDX) begin
                                state <= ST_DONE;
                            end else begin
                                pc    <= pc + 1'b1;
                                state <= ST_FETCH;
                            end
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    flseq_shifter #(
        .SR_W (SR_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (state == ST_FETCH),
        .load_val (dec_load),
        .shift_en (step),
        .plog     (plog_q),
        .drive    (state == ST_SHIFT),
        .io_out   (io_out),
        .io_oe    (io_oe)
    );

    // Interface strobes derived from the sequence state.
    always_comb begin
        cs_n   = !((state == ST_FETCH) || (state == ST_SHIFT));
        sck_en = (state == ST_SHIFT);
        sck    = sck_en && half;
        done   = (state == ST_DONE);
    end

endmodule

// File: rtl/flash_seq_exec_chk.sv
// Protocol checker for the flash sequence executor, bound to the top module.
// Assumes: port names match the top module.
module flash_seq_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cs_n,
    input logic       sck,
    input logic       sck_en,
    input logic [3:0] io_oe,
    input logic       done
);

    a_r2_cs_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start));

    a_r3_clock_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en |-> !cs_n);

    a_r4_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_en |-> (io_oe == 4'b0000));

    a_r4_pad_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en |-> (io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));

    a_r5_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_en |-> !sck);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    a_r13_cs_rises_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

endmodule

bind flash_seq_exec flash_seq_exec_chk u_chk (.*);

// File: tb/flash_seq_exec_bench.sv
// Scoreboard bench: a driver task models each programmed list and queues the
// expected pad items; a monitor pops and compares them on every shift cycle.
module flash_seq_exec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_we = 1'b0;
    logic [2:0]        prog_idx = '0;
    logic [15:0]       prog_word = '0;
    logic              start = 1'b0;
    logic              addr_from_bus = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              cs_n;
    logic              sck;
    logic              sck_en;
    logic [3:0]        io_out;
    logic [3:0]        io_oe;
    logic              done;

    flash_seq_exec #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_flash_seq_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_we       (prog_we),
        .prog_idx      (prog_idx),
        .prog_word     (prog_word),
        .start         (start),
        .addr_from_bus (addr_from_bus),
        .bus_addr      (bus_addr),
        .reg_addr      (reg_addr),
        .cs_n          (cs_n),
        .sck           (sck),
        .sck_en        (sck_en),
        .io_out        (io_out),
        .io_oe         (io_oe),
        .done          (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cs_cnt = 0;
    int          exp_cs = 0;
    int          done_cnt = 0;
    logic [8:0]  exp_q [$];
    string       req_q [$];
    logic [15:0] prog [DEPTH];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] mk(input int op, input int pc, input int opd);
        return {6'(op), 2'(pc), 8'(opd)};
    endfunction

    // Monitor: compare each shift cycle against the scoreboard, count cs and done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R13", "unexpected shift cycle", {io_out, io_oe, sck}, 0);
                end else begin
                    logic [8:0] e;
                    string      r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check({io_out, io_oe, sck} == e, r, "pad item {io,oe,sck}",
                          {io_out, io_oe, sck}, e);
                end
            end
            if (!cs_n) cs_cnt++;
            if (done) begin
                done_cnt++;
                check(cs_n == 1'b1, "R11 R12", "cs_n during done", cs_n, 1);
            end
        end
    end

    // Driver model: expected pad items and chip-select cycle count from the list.
    task automatic build_expect(input logic [ADDR_W-1:0] addr);
        exp_cs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            int          op, p, bits, units, w;
            logic [31:0] val;
            bit          ddr;
            string       rq;
            op   = int'(prog[i][15:10]);
            if (op == 0) begin
                exp_cs += 1;
                break;
            end
            p    = (prog[i][9:8] == 2'd0) ? 1 : (prog[i][9:8] == 2'd1) ? 2 : 4;
            bits = 0;
            val  = '0;
            ddr  = 1'b0;
            rq   = "R3";
            case (op)
                1: begin bits = 8; val = 32'(prog[i][7:0]); rq = "R6 R4 R5"; end
                2: begin
                    w = int'(prog[i][5:0]);
                    if (w > ADDR_W) w = ADDR_W;
                    bits = w;
                    val  = 32'(addr) & ((32'd1 << w) - 1);
                    rq   = "R9 R10 R4";
                end
                3: begin bits = 2; val = 32'(prog[i][1:0]); rq = "R7 R5"; end
                4: begin bits = 4; val = 32'(prog[i][3:0]); rq = "R7 R5"; end
                5: begin bits = 2; val = 32'(prog[i][1:0]); ddr = 1'b1; rq = "R8"; end
                6: begin bits = 4; val = 32'(prog[i][3:0]); ddr = 1'b1; rq = "R8"; end
                default: bits = 0;
            endcase
            units = (bits + p - 1) / p;
            if (units == 0) begin
                exp_cs += 1;
                continue;
            end
            exp_cs += 1 + (ddr ? units : 2 * units);
            for (int j = 0; j < units; j++) begin
                logic [3:0] io;
                logic [3:0] oe;
                io = 4'b0000;
                for (int m = 0; m < p; m++) begin
                    int k;
                    k = j * p + m;
                    io[p - 1 - m] = (k < bits) ? val[bits - 1 - k] : 1'b0;
                end
                oe = 4'((1 << p) - 1);
                if (ddr) begin
                    exp_q.push_back({io, oe, 1'(j % 2)});
                    req_q.push_back(rq);
                end else begin
                    exp_q.push_back({io, oe, 1'b0});
                    req_q.push_back(rq);
                    exp_q.push_back({io, oe, 1'b1});
                    req_q.push_back(rq);
                end
            end
        end
    endtask

    task automatic load_list();
        for (int i = 0; i < DEPTH; i++) begin
            prog_we   = 1'b1;
            prog_idx  = 3'(i);
            prog_word = prog[i];
            tick();
        end
        prog_we = 1'b0;
    endtask

    // poke > 0: extra start that many cycles into the run; poke < 0: at done.
    task automatic run(input logic [ADDR_W-1:0] addr, input bit from_bus, input int poke);
        int guard;
        addr_from_bus = from_bus;
        bus_addr      = from_bus ? addr : ~addr;
        reg_addr      = from_bus ? ~addr : addr;
        build_expect(addr);
        cs_cnt   = 0;
        done_cnt = 0;
        start    = 1'b1;
        tick();
        start    = 1'b0;
        check(cs_n == 1'b0, "R2", "cs_n after start", cs_n, 0);
        guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            if (guard == poke) start = 1'b1;
            tick();
            start = 1'b0;
            guard++;
        end
        check(done_cnt == 1, "R11 R12", "done pulse seen", done_cnt, 1);
        if (poke < 0) begin
            start = 1'b1;
            tick();
            start = 1'b0;
        end
        repeat (6) tick();
        check(done_cnt == 1, "R13", "done count after idle", done_cnt, 1);
        check(cs_cnt == exp_cs, "R3", "cs_n low cycles", cs_cnt, exp_cs);
        check(exp_q.size() == 0, "R2", "items left unsent", exp_q.size(), 0);
        exp_q.delete();
        req_q.delete();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
        check(sck_en == 1'b0 && sck == 1'b0, "R1", "sck_en/sck", {sck_en, sck}, 0);
        check(io_oe == 4'b0 && io_out == 4'b0, "R1", "io_oe/io_out", {io_oe, io_out}, 0);
        check(done == 1'b0, "R1", "done", done, 0);

        // List A: single pad, register address, ended by STOP (R11).
        prog[0] = mk(1, 0, 8'h6B);
        prog[1] = mk(2, 0, 24);
        prog[2] = mk(3, 0, 2'b10);
        prog[3] = mk(0, 0, 0);
        prog[4] = mk(1, 2, 8'hFF);
        prog[5] = mk(4, 2, 4'hF);
        prog[6] = mk(1, 0, 8'h11);
        prog[7] = mk(1, 0, 8'h22);
        load_list();
        run(24'h123456, 1'b0, 0);

        // List B: all widths and rates, no STOP, bus address, mid-run start (R12 R13).
        prog[0] = mk(1, 0, 8'hEB);
        prog[1] = mk(2, 2, 24);
        prog[2] = mk(4, 2, 4'hA);
        prog[3] = mk(3, 1, 2'b01);
        prog[4] = mk(5, 0, 2'b10);
        prog[5] = mk(6, 0, 4'h5);
        prog[6] = mk(6, 2, 4'hC);
        prog[7] = mk(2, 2, 2);
        load_list();
        run(24'hA50F3E, 1'b1, 20);

        // List C: clamped width, no-ops, zero fill, pad code 3, start at done.
        prog[0] = mk(2, 1, 40);
        prog[1] = mk(1, 1, 8'h9F);
        prog[2] = mk(9, 0, 8'h55);
        prog[3] = mk(2, 0, 0);
        prog[4] = mk(4, 0, 4'h9);
        prog[5] = mk(3, 2, 2'b11);
        prog[6] = mk(1, 3, 8'hC5);
        prog[7] = mk(0, 0, 0);
        load_list();
        run(24'hC396E1, 1'b0, -1);

        // List D: STOP at entry 0 keeps cs low for only the fetch cycle (R11).
        prog[0] = mk(0, 0, 0);
        prog[1] = mk(1, 0, 8'hAA);
        load_list();
        run(24'h000001, 1'b1, 0);

        // List E: DDR two bits on one pad, bus address width 5 on two pads (R8 R9).
        prog[0] = mk(5, 0, 2'b01);
        prog[1] = mk(2, 1, 5);
        prog[2] = mk(6, 1, 4'h6);
        prog[3] = mk(0, 0, 0);
        load_list();
        run(24'h00001B, 1'b1, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule